// File: doc/BRIEF.md
# Configurable GPIO Status Multiplexer

This block controls three open-drain I/O pins of a battery charger. Register bits set each pin on its own as a digital input, as a digital output, or as an active-low indicator for one internal charger condition. The pin never drives high. A logical 0 turns on the pull-down and a logical 1 releases the pad, so an external pull-up supplies the high level. Each pin's level passes through a synchronizer and is always readable, whatever mode the pin is in.

Each pin has one fixed status source. Pin 0 shows that charging is active, or that the charge taper point is reached when the sealed-lead-acid strap is set. Pin 1 shows a sticky backup-fault flag, which software clears through a self-clearing control bit. Pin 2 shows that calibration is complete, or shows a charge fault when the standalone (no host) strap is set. When the standalone strap is high during reset, every pin comes up as a status output. A host can change that setting later, and only a reset returns the configuration to its default.

Top module: `gpio_status_mux`

## Requirements
- R1: With the standalone strap low, reset leaves every enable, output and select bit at 0. All pads are released and the backup-fault flag is 0. Register 0 packs the enables in bits [2:0], the output values in [6:4] and the selects in [10:8], with pin i at the lowest bit of its field plus i.
- R2: With the standalone strap high during reset, every enable and select bit comes out of reset at 1 and every output bit at 0. A later write to register 0 replaces these values.
- R3: A pin whose enable bit is 0 never pulls its pad low, whatever its output and select bits hold.
- R4: A pin with enable 1 and select 0 pulls its pad low exactly when its output bit is 0.
- R5: A pin with enable 1 and select 1 pulls its pad low exactly when its status condition is true, and its output bit has no effect.
- R6: The status condition of pin 0 is true when either bit of the two-bit charge state is 1. When the lead-acid strap is high, the taper indication replaces it.
- R7: A one-cycle pulse on the backup-fault input sets the flag on the next clock. The flag stays set with no further pulses. The flag is the status condition of pin 1 and reads back in register 2 bit 4.
- R8: Writing 1 to register 1 bit 0 sets a clear request. The request clears the flag on the following clock and then returns to 0 by itself. A fault pulse in that same cycle wins over the clear.
- R9: The status condition of pin 2 is calibration-complete. When the standalone strap is high, the charge-fault input replaces it.
- R10: Register 2 bits [2:0] report the pad levels after two flop stages, in every mode, including the low level of a pad the block itself pulls down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, asserted on power-up, undervoltage or shutdown |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register index |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register index |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| chg_state | input | 2 | Charge-state bits; either one set means charging |
| taper_hit | input | 1 | Charge current has reached the taper point |
| sla_mode | input | 1 | Sealed-lead-acid chemistry strap |
| bkup_fault_set | input | 1 | Backup-fault event pulse |
| cal_done | input | 1 | Calibration cycle completed |
| chg_fault | input | 1 | Charge fault present |
| standalone | input | 1 | No-host strap |
| pad_in | input | 3 | Pad levels as seen at the pins |
| pad_oe | output | 3 | Pull-down enable per pad, 1 drives low |

## Verification
The bench sets the output and select bits while the enable bit is 0 to show that a disabled pin stays released. A design that decoded OUT before EN would pull that pad low. With select set, it toggles the output bit and expects no change on the pad. A design that merged the output value into status mode would fail this. The bench checks the flag clear cycle by cycle. A clear bit that did not self-clear would wipe out a fault arriving later, and a clear that won over a same-cycle fault would lose that event. The bench also repeats reset with the standalone strap high and checks the forced settings, the switch of pin 2 to the charge-fault source, and that a host write can override the forced settings. It measures the synchronizer latency to the cycle, so a missing or extra stage is reported.

// File: rtl/gpio_status_pkg.sv
package gpio_status_pkg;

    localparam int PIN_N = 3;

    // register indices
    localparam int REG_CFG  = 0;
    localparam int REG_CTRL = 1;
    localparam int REG_STAT = 2;

    // field positions inside the configuration register
    localparam int EN_LSB  = 0;
    localparam int OUT_LSB = 4;
    localparam int SEL_LSB = 8;

    // field positions inside the status register
    localparam int IN_LSB   = 0;
    localparam int FLAG_BIT = 4;

    // bit of the control register that requests a flag clear
    localparam int CLR_BIT = 0;

    // status source index per pin
    localparam int SRC_CHG  = 0;
    localparam int SRC_BKUP = 1;
    localparam int SRC_CAL  = 2;

    typedef struct packed {
        logic [PIN_N-1:0] en;
        logic [PIN_N-1:0] out;
        logic [PIN_N-1:0] sel;
    } pin_cfg_t;

    typedef struct packed {
        pin_cfg_t cfg;
        logic     flag;
        logic     clr;
    } ctl_state_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_comb stage_d[s] = rst_n ? raw_i : '0;
        end else begin : g_next
            always_comb stage_d[s] = rst_n ? stage_q[s-1] : '0;
        end
        always_ff @(posedge clk) begin
            stage_q[s] <= stage_d[s];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_status_src.sv
module gpio_status_src
    import gpio_status_pkg::*;
(
    input  logic [1:0]       chg_state_i,
    input  logic             taper_i,
    input  logic             sla_i,
    input  logic             flag_i,
    input  logic             cal_done_i,
    input  logic             chg_fault_i,
    input  logic             standalone_i,
    output logic [PIN_N-1:0] cond_o
);

    always_comb begin
        cond_o           = '0;
        cond_o[SRC_CHG]  = sla_i ? taper_i : (|chg_state_i);
        cond_o[SRC_BKUP] = flag_i;
        cond_o[SRC_CAL]  = standalone_i ? chg_fault_i : cal_done_i;
    end

endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv (
    input  logic en_i,
    input  logic out_i,
    input  logic sel_i,
    input  logic cond_i,
    output logic pull_low_o
);

    always_comb begin
        if (!en_i) begin
            pull_low_o = 1'b0;
        end else if (sel_i) begin
            pull_low_o = cond_i;
        end else begin
            pull_low_o = ~out_i;
        end
    end

endmodule

// File: rtl/gpio_status_mux.sv
module gpio_status_mux
    import gpio_status_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [1:0]        chg_state,
    input  logic              taper_hit,
    input  logic              sla_mode,
    input  logic              bkup_fault_set,
    input  logic              cal_done,
    input  logic              chg_fault,
    input  logic              standalone,
    input  logic [PIN_N-1:0]  pad_in,
    output logic [PIN_N-1:0]  pad_oe
);

    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(REG_CFG);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);

    ctl_state_t st_d, st_q;

    logic [PIN_N-1:0] cfg_en, cfg_out, cfg_sel;
    logic [PIN_N-1:0] cond;
    logic [PIN_N-1:0] pin_lvl;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    // next-state logic
    always_comb begin
        st_d     = st_q;
        st_d.clr = 1'b0;

        if (wr_en && wr_addr == A_CFG) begin
            st_d.cfg.en  = wr_data[EN_LSB  +: PIN_N];
            st_d.cfg.out = wr_data[OUT_LSB +: PIN_N];
            st_d.cfg.sel = wr_data[SEL_LSB +: PIN_N];
        end

        if (wr_en && wr_addr == A_CTRL && wr_data[CLR_BIT]) begin
            st_d.clr = 1'b1;
        end

        // event set wins over a pending clear
        st_d.flag = (st_q.flag & ~st_q.clr) | bkup_fault_set;

        if (!rst_n) begin
            st_d.cfg.en  = standalone ? '1 : '0;
            st_d.cfg.out = '0;
            st_d.cfg.sel = standalone ? '1 : '0;
            st_d.flag    = 1'b0;
            st_d.clr     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cfg_en  = st_q.cfg.en;
    assign cfg_out = st_q.cfg.out;
    assign cfg_sel = st_q.cfg.sel;

    gpio_status_src u_src (
        .chg_state_i  (chg_state),
        .taper_i      (taper_hit),
        .sla_i        (sla_mode),
        .flag_i       (st_q.flag),
        .cal_done_i   (cal_done),
        .chg_fault_i  (chg_fault),
        .standalone_i (standalone),
        .cond_o       (cond)
    );

    for (genvar p = 0; p < PIN_N; p++) begin : g_pin
        gpio_pin_drv u_drv (
            .en_i       (cfg_en[p]),
            .out_i      (cfg_out[p]),
            .sel_i      (cfg_sel[p]),
            .cond_i     (cond[p]),
            .pull_low_o (pad_oe[p])
        );
    end

    gpio_in_sync #(
        .W      (PIN_N),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pad_in),
        .sync_o (pin_lvl)
    );

    // read mux
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CFG: begin
                rd_data[EN_LSB  +: PIN_N] = cfg_en;
                rd_data[OUT_LSB +: PIN_N] = cfg_out;
                rd_data[SEL_LSB +: PIN_N] = cfg_sel;
            end
            A_CTRL: rd_data[CLR_BIT] = st_q.clr;
            A_STAT: begin
                rd_data[IN_LSB +: PIN_N] = pin_lvl;
                rd_data[FLAG_BIT]        = st_q.flag;
            end
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gpio_status_mux_chk.sv
module gpio_status_mux_chk #(
    parameter int N = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         strap,
    input logic         fault_set,
    input logic [N-1:0] en,
    input logic [N-1:0] out,
    input logic [N-1:0] sel,
    input logic         flag,
    input logic         clr,
    input logic [N-1:0] oe
);

    for (genvar i = 0; i < N; i++) begin : g_pin_chk
        assert_release_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !en[i] |-> !oe[i]);
        assert_dout_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (en[i] && !sel[i]) |-> (oe[i] == !out[i]));
    end

    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_set |=> flag);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    assert_clear_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !fault_set) |=> !flag);

    assert_forced_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && strap) |-> ((&en) && (&sel) && (out == '0)));

    assert_default_cfg_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && !strap) |-> (en == '0 && out == '0 && sel == '0 && !flag));

endmodule

bind gpio_status_mux gpio_status_mux_chk #(.N(gpio_status_pkg::PIN_N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap     (standalone),
    .fault_set (bkup_fault_set),
    .en        (cfg_en),
    .out       (cfg_out),
    .sel       (cfg_sel),
    .flag      (st_q.flag),
    .clr       (st_q.clr),
    .oe        (pad_oe)
);

// File: tb/gpio_status_mux_tb.sv
module gpio_status_mux_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [1:0]  chg_state = '0;
    logic        taper_hit = 1'b0;
    logic        sla_mode = 1'b0;
    logic        bkup_fault_set = 1'b0;
    logic        cal_done = 1'b0;
    logic        chg_fault = 1'b0;
    logic        standalone = 1'b0;
    logic [2:0]  ext_lvl = 3'b111;
    logic [2:0]  pad_in;
    logic [2:0]  pad_oe;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // open-drain pad with pull-up: low if block or external device pulls low
    assign pad_in = ext_lvl & ~pad_oe;

    gpio_status_mux u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .rd_addr        (rd_addr),
        .rd_data        (rd_data),
        .chg_state      (chg_state),
        .taper_hit      (taper_hit),
        .sla_mode       (sla_mode),
        .bkup_fault_set (bkup_fault_set),
        .cal_done       (cal_done),
        .chg_fault      (chg_fault),
        .standalone     (standalone),
        .pad_in         (pad_in),
        .pad_oe         (pad_oe)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    function automatic logic [15:0] cfg_word(logic [2:0] en, logic [2:0] out, logic [2:0] sel);
        return {5'b0, sel, 1'b0, out, 1'b0, en};
    endfunction

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        standalone = strap;
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_default_reset;
        logic [15:0] d;
        do_reset(1'b0);
        rd(2'd0, d);
        chk(d, 16'h0000, "R1 cfg after reset");
        chk(pad_oe, 3'b000, "R1 pads released");
        rd(2'd2, d);
        chk(d[4], 1'b0, "R1 flag clear");
    endtask

    task automatic t_disabled_pins;
        chg_state = 2'b11; cal_done = 1'b1;
        wr(2'd0, cfg_word(3'b000, 3'b000, 3'b111));
        chk(pad_oe, 3'b000, "R3 sel set, en off");
        wr(2'd0, cfg_word(3'b000, 3'b111, 3'b000));
        chk(pad_oe, 3'b000, "R3 out set, en off");
        chg_state = 2'b00; cal_done = 1'b0;
    endtask

    task automatic t_digital_out;
        wr(2'd0, cfg_word(3'b111, 3'b101, 3'b000));
        chk(pad_oe, 3'b010, "R4 out pattern 101");
        wr(2'd0, cfg_word(3'b111, 3'b010, 3'b000));
        chk(pad_oe, 3'b101, "R4 out pattern 010");
    endtask

    task automatic t_pin0_status;
        wr(2'd0, cfg_word(3'b001, 3'b000, 3'b001));
        chk(pad_oe[0], 1'b0, "R5 idle status released");
        wr(2'd0, cfg_word(3'b001, 3'b001, 3'b001));
        chk(pad_oe[0], 1'b0, "R5 out bit ignored");
        chg_state = 2'b01; #1;
        chk(pad_oe[0], 1'b1, "R6 charge bit0");
        chg_state = 2'b10; #1;
        chk(pad_oe[0], 1'b1, "R6 charge bit1");
        sla_mode = 1'b1; #1;
        chk(pad_oe[0], 1'b0, "R6 lead-acid ignores charge bits");
        taper_hit = 1'b1; #1;
        chk(pad_oe[0], 1'b1, "R6 lead-acid taper");
        sla_mode = 1'b0; taper_hit = 1'b0; chg_state = 2'b00; #1;
        chk(pad_oe[0], 1'b0, "R6 back to idle");
    endtask

    task automatic t_sticky_flag;
        logic [15:0] d;
        wr(2'd0, cfg_word(3'b010, 3'b000, 3'b010));
        chk(pad_oe[1], 1'b0, "R7 flag idle");
        bkup_fault_set = 1'b1;
        step(1);
        bkup_fault_set = 1'b0;
        chk(pad_oe[1], 1'b1, "R7 flag set drives pin");
        step(5);
        rd(2'd2, d);
        chk(d[4], 1'b1, "R7 flag stays set");
        chk(pad_oe[1], 1'b1, "R7 pin stays low");
        wr(2'd1, 16'h0001);
        rd(2'd1, d);
        chk(d[0], 1'b1, "R8 clear request visible");
        rd(2'd2, d);
        chk(d[4], 1'b1, "R8 flag still set during request");
        step(1);
        rd(2'd2, d);
        chk(d[4], 1'b0, "R8 flag cleared");
        rd(2'd1, d);
        chk(d[0], 1'b0, "R8 request self-cleared");
        chk(pad_oe[1], 1'b0, "R8 pin released");
        // later fault must set again (clear not stuck)
        bkup_fault_set = 1'b1; step(1); bkup_fault_set = 1'b0;
        step(2);
        rd(2'd2, d);
        chk(d[4], 1'b1, "R8 later fault not masked");
        // clear request and fault in the same cycle: fault wins
        wr(2'd1, 16'h0001);
        bkup_fault_set = 1'b1; step(1); bkup_fault_set = 1'b0;
        rd(2'd2, d);
        chk(d[4], 1'b1, "R8 fault beats clear");
        wr(2'd1, 16'h0001);
        step(1);
        rd(2'd2, d);
        chk(d[4], 1'b0, "R8 final clear");
    endtask

    task automatic t_pin2_host;
        wr(2'd0, cfg_word(3'b100, 3'b000, 3'b100));
        chg_fault = 1'b1; #1;
        chk(pad_oe[2], 1'b0, "R9 charge fault ignored with host");
        cal_done = 1'b1; #1;
        chk(pad_oe[2], 1'b1, "R9 calibration complete");
        cal_done = 1'b0; chg_fault = 1'b0; #1;
    endtask

    task automatic t_in_sync;
        logic [15:0] d;
        wr(2'd0, cfg_word(3'b000, 3'b000, 3'b000));
        step(3);
        rd(2'd2, d);
        chk(d[2:0], 3'b111, "R10 idle levels high");
        ext_lvl = 3'b010;
        step(1);
        rd(2'd2, d);
        chk(d[2:0], 3'b111, "R10 one stage not yet visible");
        step(1);
        rd(2'd2, d);
        chk(d[2:0], 3'b010, "R10 visible after two stages");
        ext_lvl = 3'b111;
        // own drive reflected while pin is an output
        wr(2'd0, cfg_word(3'b001, 3'b000, 3'b000));
        step(2);
        rd(2'd2, d);
        chk(d[2:0], 3'b110, "R10 own pull-down reported");
        wr(2'd0, cfg_word(3'b000, 3'b000, 3'b000));
    endtask

    task automatic t_standalone;
        logic [15:0] d;
        do_reset(1'b1);
        rd(2'd0, d);
        chk(d, cfg_word(3'b111, 3'b000, 3'b111), "R2 forced config");
        chk(pad_oe, 3'b000, "R2 all idle released");
        cal_done = 1'b1; #1;
        chk(pad_oe[2], 1'b0, "R9 calibration ignored standalone");
        chg_fault = 1'b1; #1;
        chk(pad_oe[2], 1'b1, "R9 charge fault substituted");
        wr(2'd0, cfg_word(3'b000, 3'b000, 3'b000));
        rd(2'd0, d);
        chk(d, 16'h0000, "R2 host override");
        chk(pad_oe, 3'b000, "R2 released after override");
        cal_done = 1'b0; chg_fault = 1'b0;
        do_reset(1'b0);
        rd(2'd0, d);
        chk(d, 16'h0000, "R1 default after second reset");
    endtask

    initial begin
        t_default_reset();
        t_disabled_pins();
        t_digital_out();
        t_pin0_status();
        t_sticky_flag();
        t_pin2_host();
        t_in_sync();
        t_standalone();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule